// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This is a secondary watchdog built around a modulus down counter. After reset it is already running from a programmed reset timeout. Software keeps it from expiring by writing a two-word key sequence to a service register. A completed sequence reloads the counter from the timeout register. When the counter runs out, the block takes its timeout action. Writing a value that is not a key also takes the timeout action. In window mode, so does any service key that arrives while the count is still above the window value.

The timeout action depends on the configured mode. In reset mode it raises a one-cycle system reset request. In interrupt mode the first action raises an interrupt flag and reloads the counter. A further action while that flag is still set requests reset.

The counter advances on every system clock or only on cycles where a crystal clock enable is high. A soft lock protects the configuration and is cleared by a separate two-word unlock sequence. A hard lock protects the configuration as well, and once set it stays set until reset.

Top module: `keyed_window_wdt`

## Requirements
- R1: Out of reset the watchdog is enabled in reset mode, with window mode off, system clock selected and both locks clear. The counter and the timeout register hold RST_TIMEOUT, the window holds 0, and irq and sys_rst are low.
- R2: While enabled, the counter falls by one per tick. A tick is every cycle when control bit 3 is 0, and only cycles with xtal_en high when control bit 3 is 1.
- R3: A tick at count 0 with no service in that cycle is a timeout. It reloads the counter from the timeout register (address 1), and in reset mode it drives sys_rst high for the next cycle only.
- R4: Writing 0xA602 and then 0xB480 to the service register (address 3) reloads the counter from the timeout register. B480 without a directly preceding A602 is a fault.
- R5: Any other value written to address 3 is a fault. Only 0xA602, a B480 that completes the sequence, 0xC520, and a D928 that completes the unlock sequence are accepted. A fault takes the timeout action and reloads the counter.
- R6: With window mode on (control bit 2), writing A602 or B480 while the count is above the window register (address 2) is a fault. At or below the window, the sequence is accepted.
- R7: In interrupt mode (control bit 1), a timeout action with irq low sets irq and reloads the counter without sys_rst. An action while irq is high pulses sys_rst. Writing control with bit 8 set clears irq whatever the locks are, and control bit 8 reads back irq.
- R8: Control bit 4 sets the soft lock. While it is set, writes to control fields, timeout and window are ignored. Writing 0xC520 and then 0xD928 to address 3 clears it.
- R9: Control bit 5 sets the hard lock. It blocks the same writes, the unlock sequence does not clear it, and only reset removes it.
- R10: With control bit 0 clear, the counter holds and no fault or timeout produces irq or sys_rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_en | input | 1 | Crystal clock enable, used when the crystal source is selected |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 timeout, 2 window, 3 service |
| wr_data | input | CW | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 timeout, 2 window, 3 current count |
| rd_data | output | CW | Combinational read data |
| irq | output | 1 | Interrupt request flag |
| sys_rst | output | 1 | One-cycle system reset request |

## Verification
A write or tick that the block samples on a rising edge changes its state on that same edge. The count and register read data follow one edge after the write cycle, because rd_data decodes the state combinationally. The irq and sys_rst outputs are registered, so a timeout or fault shows on them during the cycle right after the edge that detected it.

The bench drives inputs just after the falling edge and samples all outputs on the falling edge. Its behavioural model advances on the same rising edge as the design, so the model and the design are compared on every clock. The targeted checks read the count right after a write task returns, which is exactly one edge after the write was taken.

// File: rtl/keyed_window_wdt.sv
`timescale 1ns/1ps
module keyed_window_wdt #(
  parameter int CW = 32,
  parameter logic [CW-1:0] RST_TIMEOUT = CW'(1000),
  parameter logic [15:0] KEY_SVC1 = 16'hA602,
  parameter logic [15:0] KEY_SVC2 = 16'hB480,
  parameter logic [15:0] KEY_ULK1 = 16'hC520,
  parameter logic [15:0] KEY_ULK2 = 16'hD928
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xtal_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  output logic          irq,
  output logic          sys_rst
);
  localparam logic [1:0] A_CTRL = 2'd0, A_TMO = 2'd1, A_WIN = 2'd2, A_SVC = 2'd3;

  logic en, irq_mode, win_en, clk_sel, soft_lock, hard_lock;
  logic irq_flag, svc_armed, ulk_armed;
  logic [CW-1:0] cnt, timeout, window;

  wire tick    = en & (clk_sel ? xtal_en : 1'b1);
  wire svc_wr  = wr_en && wr_addr == A_SVC;
  wire cfg_wr  = wr_en && !soft_lock && !hard_lock;
  wire early   = win_en && (cnt > window);
  wire is_s1   = wr_data == CW'(KEY_SVC1);
  wire is_s2   = wr_data == CW'(KEY_SVC2);
  wire is_u1   = wr_data == CW'(KEY_ULK1);
  wire is_u2   = wr_data == CW'(KEY_ULK2);
  wire svc_ok  = svc_wr && is_s2 && svc_armed && !early;
  wire ulk_ok  = svc_wr && is_u2 && ulk_armed;
  wire fault   = svc_wr && !((is_s1 && !early) || svc_ok || is_u1 || ulk_ok);
  wire tmo_hit = tick && cnt == '0 && !svc_ok;
  wire evt     = en && (fault || tmo_hit);
  wire to_irq  = evt && irq_mode && !irq_flag;

  assign irq = irq_flag;

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = CW'({irq_flag, 2'b00, hard_lock, soft_lock, clk_sel, win_en, irq_mode, en});
      A_TMO:   rd_data = timeout;
      A_WIN:   rd_data = window;
      default: rd_data = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b1; irq_mode <= 1'b0; win_en <= 1'b0; clk_sel <= 1'b0;
      soft_lock <= 1'b0; hard_lock <= 1'b0;
      irq_flag <= 1'b0; svc_armed <= 1'b0; ulk_armed <= 1'b0;
      cnt <= RST_TIMEOUT; timeout <= RST_TIMEOUT; window <= '0;
      sys_rst <= 1'b0;
    end else begin
      sys_rst <= evt && !to_irq;
      if (evt || svc_ok) cnt <= timeout;
      else if (tick)     cnt <= cnt - 1'b1;

      if (to_irq) irq_flag <= 1'b1;
      else if (wr_en && wr_addr == A_CTRL && wr_data[8]) irq_flag <= 1'b0;

      if (svc_wr) begin
        svc_armed <= is_s1 && !early;
        ulk_armed <= is_u1;
      end

      if (ulk_ok) soft_lock <= 1'b0;
      else if (cfg_wr && wr_addr == A_CTRL) begin
        en <= wr_data[0]; irq_mode <= wr_data[1]; win_en <= wr_data[2];
        clk_sel <= wr_data[3]; soft_lock <= wr_data[4]; hard_lock <= wr_data[5];
      end
      if (cfg_wr && wr_addr == A_TMO) timeout <= wr_data;
      if (cfg_wr && wr_addr == A_WIN) window  <= wr_data;
    end
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !evt && !svc_ok) |=> cnt == $past(cnt) - 1'b1);
  // R10
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !svc_ok) |=> (cnt == $past(cnt) && !sys_rst && !$rose(irq_flag)));
  // R9
  hard_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_lock |=> hard_lock);
  // R7
  irq_only_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> ($past(irq_mode) && !sys_rst));
  // R3
  rst_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> ($past(en) && cnt == $past(timeout)));
endmodule

// File: tb/sim_keyed_window_wdt.sv
`timescale 1ns/1ps
module sim_keyed_window_wdt;
  logic clk = 1'b0, rst_n = 1'b0, xtal_en = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = 2'd3;
  logic [31:0] wr_data = '0, rd_data;
  logic irq, sys_rst;
  int nchk = 0, nfail = 0, pulses = 0;
  string phase = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  keyed_window_wdt u0 (.clk, .rst_n, .xtal_en, .wr_en, .wr_addr, .wr_data,
                       .rd_addr, .rd_data, .irq, .sys_rst);

  // behavioural reference
  bit m_en = 1, m_im = 0, m_we = 0, m_cs = 0, m_sl = 0, m_hl = 0;
  bit m_flag = 0, m_svc = 0, m_ulk = 0, m_rst = 0;
  logic [31:0] m_cnt = 1000, m_tmo = 1000, m_win = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 1; m_im = 0; m_we = 0; m_cs = 0; m_sl = 0; m_hl = 0;
      m_flag = 0; m_svc = 0; m_ulk = 0; m_rst = 0;
      m_cnt = 1000; m_tmo = 1000; m_win = 0;
    end else begin
      bit tk, sw, ea, ok, uk, fl, ev, ti, unl;
      tk = m_en && (m_cs ? xtal_en : 1'b1);
      sw = wr_en && wr_addr == 3;
      ea = m_we && (m_cnt > m_win);
      ok = sw && wr_data == 32'hB480 && m_svc && !ea;
      uk = sw && wr_data == 32'hD928 && m_ulk;
      fl = sw && !((wr_data == 32'hA602 && !ea) || ok || wr_data == 32'hC520 || uk);
      ev = m_en && (fl || (tk && m_cnt == 0 && !ok));
      ti = ev && m_im && !m_flag;
      unl = !m_sl && !m_hl;
      m_rst = ev && !ti;
      if (ev || ok) m_cnt = m_tmo; else if (tk) m_cnt = m_cnt - 1;
      if (ti) m_flag = 1; else if (wr_en && wr_addr == 0 && wr_data[8]) m_flag = 0;
      if (sw) begin m_svc = (wr_data == 32'hA602) && !ea; m_ulk = (wr_data == 32'hC520); end
      if (uk) m_sl = 0;
      else if (wr_en && unl && wr_addr == 0) begin
        m_en = wr_data[0]; m_im = wr_data[1]; m_we = wr_data[2];
        m_cs = wr_data[3]; m_sl = wr_data[4]; m_hl = wr_data[5];
      end
      if (wr_en && unl && wr_addr == 1) m_tmo = wr_data;
      if (wr_en && unl && wr_addr == 2) m_win = wr_data;
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {23'd0, m_flag, 2'b00, m_hl, m_sl, m_cs, m_we, m_im, m_en};
      2'd1: return m_tmo;
      2'd2: return m_win;
      default: return m_cnt;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (sys_rst) pulses++;
    chk({phase, " model irq"}, 32'(irq), 32'(m_flag));
    chk({phase, " model sys_rst"}, 32'(sys_rst), 32'(m_rst));
    chk({phase, " model rd_data"}, rd_data, m_read(rd_addr));
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data; rd_addr = 2'd3;
  endtask

  task automatic service();
    wr(3, 32'hA602); wr(3, 32'hB480);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired in phase %s actual=hung expected=done", phase);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk); #1;
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 32'h1);
    rd(1, v); chk("R1 timeout", v, 32'd1000);
    rd(2, v); chk("R1 window", v, 32'd0);
    rd(3, v); chk("R1 count", v, 32'd1000);
    chk("R1 irq", 32'(irq), 0); chk("R1 sys_rst", 32'(sys_rst), 0);
    @(negedge clk); #1 rst_n = 1;
    // R3 default timeout, reset mode
    phase = "R3"; pulses = 0;
    repeat (1100) @(negedge clk); #1;
    chk("R3 single reset pulse per period", 32'(pulses), 1);
    // R4 service
    phase = "R4";
    wr(1, 32'd30); service();
    rd(3, v); chk("R4 reload after keys", v, 32'd30);
    wr(3, 32'hB480); chk("R4 lone B480 faults", 32'(sys_rst), 1);
    // R5 bad key
    phase = "R5";
    repeat (3) @(negedge clk); #1;
    wr(3, 32'h1234);
    chk("R5 bad key reset", 32'(sys_rst), 1);
    rd(3, v); chk("R5 bad key reload", v, 32'd30);
    // R6 window
    phase = "R6";
    wr(2, 32'd10); wr(0, 32'h5);
    wr(3, 32'hA602);
    chk("R6 early key faults", 32'(sys_rst), 1);
    rd(3, v);
    while (v > 8) begin @(negedge clk); #1; rd(3, v); end
    pulses = 0; service();
    chk("R6 in-window no fault", 32'(pulses), 0);
    rd(3, v); chk("R6 in-window reload", v, 32'd30);
    // R7 interrupt mode
    phase = "R7";
    wr(0, 32'h3); service(); pulses = 0;
    repeat (40) @(negedge clk); #1;
    chk("R7 first timeout irq", 32'(irq), 1);
    chk("R7 first timeout no reset", 32'(pulses), 0);
    repeat (30) @(negedge clk); #1;
    chk("R7 second timeout resets", 32'(pulses), 1);
    wr(0, 32'h103);
    chk("R7 irq cleared", 32'(irq), 0);
    // R2 crystal enable
    phase = "R2";
    wr(0, 32'h9); service();
    xtal_en = 0;
    repeat (10) @(negedge clk); #1;
    rd(3, v); chk("R2 no tick without xtal_en", v, 32'd30);
    for (int i = 0; i < 10; i++) begin xtal_en = (i % 2 == 0); @(negedge clk); #1; end
    rd(3, v); chk("R2 five crystal ticks", v, 32'd25);
    xtal_en = 1;
    // R10 disabled
    phase = "R10";
    wr(0, 32'h0); rd(3, v); pulses = 0;
    repeat (50) @(negedge clk); #1;
    begin logic [31:0] w; rd(3, w); chk("R10 count holds", w, v); end
    wr(3, 32'h5555);
    chk("R10 no action on fault", 32'(pulses), 0);
    // R8 soft lock
    phase = "R8";
    wr(0, 32'h11); service();
    wr(1, 32'd99); rd(1, v); chk("R8 locked timeout write ignored", v, 32'd30);
    wr(0, 32'h3); rd(0, v); chk("R8 locked ctrl write ignored", v, 32'h11);
    wr(3, 32'hC520); wr(3, 32'hD928);
    wr(1, 32'd40); rd(1, v); chk("R8 unlocked write taken", v, 32'd40);
    service();
    // R9 hard lock
    phase = "R9";
    wr(0, 32'h21);
    wr(1, 32'd77); rd(1, v); chk("R9 hard-locked timeout ignored", v, 32'd40);
    wr(3, 32'hC520); wr(3, 32'hD928);
    wr(2, 32'd5); rd(2, v); chk("R9 unlock keys do not help", v, 32'd10);
    wr(0, 32'h0); rd(0, v); chk("R9 ctrl unchanged", v, 32'h21);
    service();
    repeat (5) @(negedge clk); #1;
    finish_run();
  end
endmodule